// File: doc/BRIEF.md
# Fixed-Window Hardware Stack Pointer

This block is the stack pointer of a small 8-bit processor core. It keeps a 13-bit stack address. The top seven bits of that address are fixed at `0000011`, so every address lies in the 64-byte window from `0x00C0` to `0x00FF`. Only a 6-bit offset is counted. When more than 64 bytes are stacked, the offset wraps around inside the window and overwrites older bytes. No error is raised when this happens.

The core's sequencer can move the pointer one byte at a time with single push and pull strobes. It can also start a multi-byte frame, which the block then steps through on its own, one byte per cycle:

- a two-byte subroutine frame;
- a five-byte interrupt frame;
- the return sequence for either of these frames.

On each step the block drives the memory address and a read or write strobe. It also drives a code that names the register byte to store or restore. The memory array and the register file sit outside this block.

Top module: `stack_window_ptr`

## Requirements
- R1: After `rst_n` is released, `sp_addr` is `0x00FF`, `busy` is 0, `byte_sel` is 0 and no memory strobe is active.
- R2: `sp_addr[12:6]` and `mem_addr[12:6]` are always `0000011`, so both addresses stay within `0x00C0..0x00FF`.
- R3: A single push (`push`=1, `pull`=0, idle, no `rsp_cmd`) does the following:
  - asserts `mem_we` with `mem_addr` equal to `sp_addr` in the same cycle;
  - makes `sp_addr` one lower in the next cycle.
- R4: A single pull (`pull`=1, `push`=0, idle, no `rsp_cmd`) does the following:
  - asserts `mem_re` with `mem_addr` equal to `sp_addr`+1 in the same cycle;
  - makes `sp_addr` equal to that address in the next cycle.
- R5: The offset wraps silently in both directions:
  - a push at `0x00C0` leaves `sp_addr` at `0x00FF`;
  - a pull at `0x00FF` reads `0x00C0` and leaves `sp_addr` there.
- R6: `rsp_cmd` takes priority over every other input. In that cycle it does the following:
  - suppresses all memory strobes and sets `byte_sel` to 0;
  - cancels any frame in progress;
  - sets `sp_addr` to `0x00FF` in the next cycle.
- R7: When idle, `push` and `pull` together do the following:
  - pulse `proto_err` in that cycle;
  - produce no memory strobe;
  - leave `sp_addr` unchanged.
- R8: `frame_go` with `frame_kind`=0 (call) makes `busy` go high in the next cycle. The block then makes two push steps with `byte_sel` 1 (PC low), then 2 (PC high).
- R9: `frame_kind`=1 (interrupt) makes five push steps with `byte_sel` 1, 2, 3, 4, 5. These codes stand for PC low, PC high, index, accumulator and condition codes.
- R10: `frame_kind`=2 (return) makes two pull steps with `byte_sel` 2, then 1.
- R11: `frame_kind`=3 (return from interrupt) makes five pull steps with `byte_sel` 5, 4, 3, 2, 1.
- R12: While `busy`, the block ignores `push`, `pull` and `frame_go`. It raises no `proto_err`, and each step of the frame still takes place.
- R13: When idle, `frame_go` is ignored in any cycle where `push`, `pull` or `rsp_cmd` is also asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push | input | 1 | Single-byte push strobe |
| pull | input | 1 | Single-byte pull strobe |
| rsp_cmd | input | 1 | Reset-stack-pointer command |
| frame_go | input | 1 | Start a frame sequence |
| frame_kind | input | 2 | Frame kind: 0 call, 1 interrupt, 2 return, 3 return from interrupt |
| sp_addr | output | 13 | Current stack pointer (next free location) |
| mem_addr | output | 13 | Address of this cycle's stack access |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Stack read strobe |
| byte_sel | output | 3 | Register byte of the frame step (0 none, 1 PCL, 2 PCH, 3 X, 4 A, 5 CCR) |
| busy | output | 1 | Frame sequence in progress |
| proto_err | output | 1 | Push and pull were asserted together while idle |

## Verification
The properties treat every input as synchronous to `clk` and free of unknown values once reset is released. They put no limit on the order of commands. Any mix of push, pull, frame starts and pointer resets must keep them true, including collisions during a frame. The stimulus drives inputs only on the falling edge. Its directed runs include:

- pushing more than 64 bytes to force the wrap;
- starting each frame kind;
- colliding strobes during a frame.

A random phase then mixes every input freely. That phase stays within the same single-edge timing.

// File: rtl/stack_window_ptr.sv
module stack_window_ptr #(
  parameter int ADDR_W = 13,
  parameter int OFS_W  = 6,
  parameter logic [ADDR_W-OFS_W-1:0] PAGE = 7'b0000011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pull,
  input  logic              rsp_cmd,
  input  logic              frame_go,
  input  logic [1:0]        frame_kind,
  output logic [ADDR_W-1:0] sp_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [2:0]        byte_sel,
  output logic              busy,
  output logic              proto_err
);
  localparam logic [OFS_W-1:0] TOP = '1;

  logic [OFS_W-1:0] ofs;
  logic             busy_q;
  logic [1:0]       kind_q;
  logic [2:0]       step_q;

  wire frm      = busy_q & ~rsp_cmd;
  wire idle_ok  = ~busy_q & ~rsp_cmd;
  wire raw_push = idle_ok & push & ~pull;
  wire raw_pull = idle_ok & pull & ~push;
  wire go_ok    = idle_ok & frame_go & ~push & ~pull;

  wire [OFS_W-1:0] ofs_up = ofs + OFS_W'(1);
  wire [OFS_W-1:0] ofs_dn = ofs - OFS_W'(1);
  wire [2:0]       last   = kind_q[0] ? 3'd4 : 3'd1;
  wire [2:0]       len    = last + 3'd1;

  assign mem_we    = (frm & ~kind_q[1]) | raw_push;
  assign mem_re    = (frm &  kind_q[1]) | raw_pull;
  assign proto_err = ~busy_q & push & pull;
  assign busy      = busy_q;
  assign sp_addr   = {PAGE, ofs};
  assign mem_addr  = {PAGE, mem_re ? ofs_up : ofs};
  assign byte_sel  = !frm ? 3'd0 : (kind_q[1] ? len - step_q : step_q + 3'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs    <= TOP;
      busy_q <= 1'b0;
      kind_q <= 2'd0;
      step_q <= 3'd0;
    end else if (rsp_cmd) begin
      ofs    <= TOP;
      busy_q <= 1'b0;
      step_q <= 3'd0;
    end else begin
      if (mem_we)      ofs <= ofs_dn;
      else if (mem_re) ofs <= ofs_up;
      if (go_ok) begin
        busy_q <= 1'b1;
        kind_q <= frame_kind;
        step_q <= 3'd0;
      end else if (busy_q) begin
        if (step_q == last) begin
          busy_q <= 1'b0;
          step_q <= 3'd0;
        end else begin
          step_q <= step_q + 3'd1;
        end
      end
    end
  end
endmodule

module stack_window_ptr_chk #(
  parameter int ADDR_W = 13,
  parameter int OFS_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push,
  input logic              pull,
  input logic              rsp_cmd,
  input logic              frame_go,
  input logic [ADDR_W-1:0] sp_addr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              mem_re,
  input logic [2:0]        byte_sel,
  input logic              busy,
  input logic              proto_err
);
  a_r2_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr[ADDR_W-1:OFS_W] == sp_addr[ADDR_W-1:OFS_W]);
  a_r3_push_here: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == sp_addr) && !mem_re);
  a_r3_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp_addr[OFS_W-1:0] == $past(sp_addr[OFS_W-1:0]) - OFS_W'(1));
  a_r4_pull_inc: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> sp_addr == $past(mem_addr));
  a_r5_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && sp_addr[OFS_W-1:0] == '0) |=> sp_addr[OFS_W-1:0] == '1);
  a_r6_rsp_top: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_cmd |=> (sp_addr[OFS_W-1:0] == '1) && !busy);
  a_r6_rsp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_cmd |-> !mem_we && !mem_re && byte_sel == 3'd0);
  a_r7_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (proto_err && !rsp_cmd) |=> $stable(sp_addr));
  a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> !mem_we && !mem_re);
  a_r8_go_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_go && !busy && !push && !pull && !rsp_cmd) |=> busy);
  a_r12_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rsp_cmd) |-> !proto_err && byte_sel != 3'd0 && $onehot({mem_we, mem_re}));
endmodule

bind stack_window_ptr stack_window_ptr_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (.*);

// File: tb/test_stack_window_ptr.sv
module test_stack_window_ptr;
  logic clk = 0, rst_n = 0;
  logic push = 0, pull = 0, rsp_cmd = 0, frame_go = 0;
  logic [1:0] frame_kind = 0;
  logic [12:0] sp_addr, mem_addr;
  logic mem_we, mem_re, busy, proto_err;
  logic [2:0] byte_sel;

  stack_window_ptr i_stack_window_ptr (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int m_sp = 63;
  int m_q[$];

  task automatic chk(string tag, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, nm, act, exp);
    end
  endtask

  task automatic cyc(bit p, bit u, bit g, int k, bit r, string tag);
    bit bz, we, re;
    int sel, ma;
    push = p; pull = u; frame_go = g; frame_kind = 2'(k); rsp_cmd = r;
    #1;
    bz = m_q.size() > 0;
    we = 0; re = 0; sel = 0;
    if (r) begin end
    else if (bz) begin
      we = (m_q[0] / 8) == 0; re = !we; sel = m_q[0] % 8;
    end else begin
      we = p && !u; re = u && !p;
    end
    ma = 'hC0 + (re ? (m_sp + 1) % 64 : m_sp);
    chk(tag, "sp_addr", sp_addr, 'hC0 + m_sp);
    chk(tag, "mem_addr", mem_addr, ma);
    chk(tag, "mem_we", mem_we, we);
    chk(tag, "mem_re", mem_re, re);
    chk(tag, "byte_sel", byte_sel, sel);
    chk(tag, "busy", busy, bz);
    chk(tag, "proto_err", proto_err, !bz && p && u);
    @(posedge clk);
    if (r) begin m_sp = 63; m_q.delete(); end
    else begin
      if (we) m_sp = (m_sp + 63) % 64;
      if (re) m_sp = (m_sp + 1) % 64;
      if (bz) void'(m_q.pop_front());
      else if (g && !p && !u) begin
        case (k)
          0: m_q = '{1, 2};
          1: m_q = '{1, 2, 3, 4, 5};
          2: m_q = '{8+2, 8+1};
          default: m_q = '{8+5, 8+4, 8+3, 8+2, 8+1};
        endcase
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1", "reset sp_addr", sp_addr, 'h00FF);
    chk("R1", "reset busy", busy, 0);
    idle(2, "R1");
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 0, "R3");
    #1 chk("R3", "sp after 5 pushes", sp_addr, 'h00FA);
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, 0, "R4");
    cyc(1, 1, 0, 0, 0, "R7");
    #1 chk("R7", "sp held", sp_addr, 'h00FD);
    for (int i = 0; i < 70; i++) cyc(1, 0, 0, 0, 0, "R5");
    for (int i = 0; i < 70; i++) cyc(0, 1, 0, 0, 0, "R5");
    cyc(0, 0, 0, 0, 1, "R6");
    #1 chk("R6", "sp after rsp", sp_addr, 'h00FF);
    cyc(0, 1, 0, 0, 0, "R5");
    #1 chk("R5", "pull wraps to C0", sp_addr, 'h00C0);
    cyc(0, 0, 1, 0, 0, "R8"); idle(3, "R8");
    cyc(0, 0, 1, 1, 0, "R9"); idle(6, "R9");
    cyc(0, 0, 1, 2, 0, "R10"); idle(3, "R10");
    cyc(0, 0, 1, 3, 0, "R11"); idle(6, "R11");
    #1 chk("R11", "sp after frames", sp_addr, 'h00C0);
    cyc(0, 0, 1, 1, 0, "R12");
    cyc(1, 1, 0, 0, 0, "R12");
    cyc(1, 0, 1, 3, 0, "R12");
    cyc(0, 1, 0, 0, 0, "R12");
    idle(3, "R12");
    cyc(0, 0, 1, 1, 0, "R6");
    cyc(0, 0, 0, 0, 0, "R6");
    cyc(0, 0, 0, 0, 1, "R6");
    idle(2, "R6");
    cyc(1, 0, 1, 0, 0, "R13");
    cyc(0, 1, 1, 1, 0, "R13");
    cyc(0, 0, 1, 2, 1, "R13");
    #1 chk("R13", "busy stays low", busy, 0);
    idle(1, "R13");
    for (int i = 0; i < 3000; i++)
      cyc($urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0, $urandom_range(0, 4) == 0,
          $urandom_range(0, 3), $urandom_range(0, 60) == 0, "R2");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule